// File: doc/BRIEF.md
# Memory Operation Queue with Store-to-Load Forwarding

The block keeps every in-flight memory operation in a circular buffer, ordered as the program issued them. An entry is claimed at dispatch with a kind flag (load or store) and a sequence number, and the block returns the index it chose. A store then gets its address and its data through two independent write ports, in either order and in separate cycles. Stores do not touch the cache while they wait. They are written out one at a time from the oldest end when the commit logic retires them.

A load that executes gives its own entry index and address, together with the word the data cache read for that address in the same cycle. The block searches the older entries for stores whose address is already known and equal to the load's address. It selects the one nearest the load in program order, and this search still works when the buffer has wrapped past its last slot. If that store's data is present, the load gets the forwarded word. If the data is missing, the load is told to wait. If no store matches, the cache word passes through unchanged. The lookup is purely combinational.

Top module: `lsq_fwd`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o is 1, retire_ready_o is 0 and cache_we_o is 0.
- R2: Allocation fills slots in order starting at index 0 and wraps modulo DEPTH. alloc_idx_o shows the next slot. When DEPTH entries are held, alloc_ready_o is 0 and a request is ignored.
- R3: Store address and store data may arrive in either order and in different cycles. A store at the head is retire-ready only once both have arrived. A load at the head is always retire-ready.
- R4: A load with no older address-known store at the same address returns cache_rdata_i, with ld_hit_o=0 and ld_wait_o=0, in the same cycle.
- R5: A load with an older matching store whose data has arrived returns that store's data with ld_hit_o=1.
- R6: When several older stores match, the load uses the youngest of them.
- R7: Stores younger than the load are never used, even if their address matches.
- R8: If the selected store has no data yet, ld_wait_o=1, ld_hit_o=0 and ld_data_o=0.
- R9: Older stores whose address has not arrived are skipped by the search.
- R10: The age order is correct when the live region wraps past index DEPTH-1 and when the load is not the youngest entry.
- R11: Retiring a head store drives cache_we_o=1 with that store's address and data in the same cycle, then frees the slot. Retiring a head load frees the slot with no cache write.
- R12: retire_i while retire_ready_o=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request a new entry |
| alloc_is_store_i | input | 1 | 1 = store, 0 = load |
| alloc_seq_i | input | SEQ_W | Sequence number of the operation |
| alloc_ready_o | output | 1 | A slot is free |
| alloc_idx_o | output | IDX_W | Index the next allocation takes |
| sta_valid_i | input | 1 | Store address write |
| sta_idx_i | input | IDX_W | Entry receiving the address |
| sta_addr_i | input | ADDR_W | Store address |
| std_valid_i | input | 1 | Store data write |
| std_idx_i | input | IDX_W | Entry receiving the data |
| std_data_i | input | DATA_W | Store data |
| ld_valid_i | input | 1 | Load lookup request |
| ld_idx_i | input | IDX_W | Entry of the executing load |
| ld_addr_i | input | ADDR_W | Load address |
| cache_rdata_i | input | DATA_W | Word read by the data cache this cycle |
| ld_hit_o | output | 1 | Data forwarded from a store |
| ld_wait_o | output | 1 | Matching store lacks data |
| ld_data_o | output | DATA_W | Load result |
| retire_i | input | 1 | Retire the head entry |
| retire_ready_o | output | 1 | Head entry may retire |
| retire_seq_o | output | SEQ_W | Sequence number of the head entry |
| cache_we_o | output | 1 | Cache write strobe |
| cache_addr_o | output | ADDR_W | Cache write address |
| cache_wdata_o | output | DATA_W | Cache write data |

## Verification
The hardest case to reach is a load whose older stores sit on both sides of the wrap point. One of them already has its address and data, another has only its address, and a third has neither. The stimulus first fills all eight slots and drains six of them. It leaves the head blocked on a store that is missing its address. Then it allocates past index 7 and tries each combination of halves in turn. A reference model made of plain arrays predicts every output on every cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } lsq_op_e;
endpackage

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
    end
  end

  assign head_o  = head_q[IDX_W-1:0];
  assign tail_o  = tail_q[IDX_W-1:0];
  // extra wrap bit separates full from empty
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
endmodule

// File: rtl/lsq_age_search.sv
module lsq_age_search
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             head_i,
  input  logic [IDX_W-1:0]             ld_idx_i,
  input  logic [ADDR_W-1:0]            ld_addr_i,
  input  lsq_op_e [DEPTH-1:0]          kind_i,
  input  logic [DEPTH-1:0]             addr_vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             sel_o
);
  logic [IDX_W-1:0] ld_dist;
  logic [IDX_W-1:0] slot;

  assign ld_dist = ld_idx_i - head_i;

  // walk oldest to youngest; the last match before the load wins
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    slot    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_i + IDX_W'(k);
      if ((IDX_W'(k) < ld_dist) && (kind_i[slot] == OP_STORE) &&
          addr_vld_i[slot] && (addr_i[slot] == ld_addr_i)) begin
        found_o = 1'b1;
        sel_o   = slot;
      end
    end
  end
endmodule

// File: rtl/lsq_fwd.sv
module lsq_fwd
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_is_store_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              sta_valid_i,
  input  logic [IDX_W-1:0]  sta_idx_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  input  logic              std_valid_i,
  input  logic [IDX_W-1:0]  std_idx_i,
  input  logic [DATA_W-1:0] std_data_i,
  input  logic              ld_valid_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] cache_rdata_i,
  output logic              ld_hit_o,
  output logic              ld_wait_o,
  output logic [DATA_W-1:0] ld_data_o,
  input  logic              retire_i,
  output logic              retire_ready_o,
  output logic [SEQ_W-1:0]  retire_seq_o,
  output logic              cache_we_o,
  output logic [ADDR_W-1:0] cache_addr_o,
  output logic [DATA_W-1:0] cache_wdata_o
);
  lsq_op_e [DEPTH-1:0]             kind_q;
  logic    [DEPTH-1:0]             avld_q, dvld_q;
  logic    [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic    [DEPTH-1:0][DATA_W-1:0] data_q;
  logic    [DEPTH-1:0][SEQ_W-1:0]  seq_q;

  logic [IDX_W-1:0] head_idx, tail_idx, fwd_sel;
  logic             full, empty, fwd_found;
  logic             alloc_fire, retire_fire;

  assign alloc_fire  = alloc_valid_i && !full;
  assign retire_fire = retire_i && retire_ready_o;

  lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (retire_fire),
    .head_o  (head_idx),
    .tail_o  (tail_idx),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= {DEPTH{OP_LOAD}};
      avld_q <= '0;
      dvld_q <= '0;
    end else begin
      if (sta_valid_i) avld_q[sta_idx_i] <= 1'b1;
      if (std_valid_i) dvld_q[std_idx_i] <= 1'b1;
      if (alloc_fire) begin
        kind_q[tail_idx] <= alloc_is_store_i ? OP_STORE : OP_LOAD;
        avld_q[tail_idx] <= 1'b0;
        dvld_q[tail_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (sta_valid_i) addr_q[sta_idx_i] <= sta_addr_i;
    if (std_valid_i) data_q[std_idx_i] <= std_data_i;
    if (alloc_fire)  seq_q[tail_idx]   <= alloc_seq_i;
  end

  lsq_age_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_search (
    .head_i     (head_idx),
    .ld_idx_i   (ld_idx_i),
    .ld_addr_i  (ld_addr_i),
    .kind_i     (kind_q),
    .addr_vld_i (avld_q),
    .addr_i     (addr_q),
    .found_o    (fwd_found),
    .sel_o      (fwd_sel)
  );

  assign ld_hit_o  = ld_valid_i && fwd_found && dvld_q[fwd_sel];
  assign ld_wait_o = ld_valid_i && fwd_found && !dvld_q[fwd_sel];
  assign ld_data_o = !fwd_found      ? cache_rdata_i :
                     dvld_q[fwd_sel] ? data_q[fwd_sel] : '0;

  assign alloc_ready_o  = !full;
  assign alloc_idx_o    = tail_idx;
  assign retire_ready_o = !empty && ((kind_q[head_idx] == OP_LOAD) ||
                                     (avld_q[head_idx] && dvld_q[head_idx]));
  assign retire_seq_o   = seq_q[head_idx];
  assign cache_we_o     = retire_fire && (kind_q[head_idx] == OP_STORE);
  assign cache_addr_o   = addr_q[head_idx];
  assign cache_wdata_o  = data_q[head_idx];
endmodule

// File: rtl/lsq_fwd_chk.sv
module lsq_fwd_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              alloc_ready_o,
  input logic [IDX_W-1:0]  alloc_idx_o,
  input logic              ld_valid_i,
  input logic              ld_hit_o,
  input logic              ld_wait_o,
  input logic [DATA_W-1:0] ld_data_o,
  input logic [DATA_W-1:0] cache_rdata_i,
  input logic              retire_i,
  input logic              retire_ready_o,
  input logic              cache_we_o,
  input logic [IDX_W-1:0]  head_idx
);
  assert_full_holds_tail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_ready_o) |=> $stable(alloc_idx_o));

  assert_alloc_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |=> (alloc_idx_o == IDX_W'($past(alloc_idx_o) + 1'b1)));

  assert_hit_wait_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && ld_wait_o));

  assert_wait_zero_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wait_o |-> (ld_data_o == '0));

  assert_miss_passes_cache_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !ld_hit_o && !ld_wait_o) |-> (ld_data_o == cache_rdata_i));

  assert_drain_on_retire_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_we_o |-> (retire_i && retire_ready_o));

  assert_blocked_retire_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !retire_ready_o) |=> $stable(head_idx));
endmodule

bind lsq_fwd lsq_fwd_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_idx_o    (alloc_idx_o),
  .ld_valid_i     (ld_valid_i),
  .ld_hit_o       (ld_hit_o),
  .ld_wait_o      (ld_wait_o),
  .ld_data_o      (ld_data_o),
  .cache_rdata_i  (cache_rdata_i),
  .retire_i       (retire_i),
  .retire_ready_o (retire_ready_o),
  .cache_we_o     (cache_we_o),
  .head_idx       (head_idx)
);

// File: tb/sim_lsq_fwd.sv
module sim_lsq_fwd;
  localparam int CLK_P = 10;
  localparam int D  = 8;
  localparam int IW = 3;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 8;

  logic clk = 0, rst_n = 0;
  logic alloc_v = 0, alloc_st = 0;
  logic [SW-1:0] alloc_seq = '0;
  logic sta_v = 0, std_v = 0, ld_v = 0, ret = 0;
  logic [IW-1:0] sta_idx = '0, std_idx = '0, ld_idx = '0;
  logic [AW-1:0] sta_addr = '0, ld_addr = '0;
  logic [DW-1:0] std_data = '0, cache_rd = '0;
  logic alloc_rdy, ld_hit, ld_wait, ret_rdy, c_we;
  logic [IW-1:0] alloc_idx;
  logic [DW-1:0] ld_data, c_wdata;
  logic [AW-1:0] c_addr;
  logic [SW-1:0] ret_seq;

  always #(CLK_P/2) clk = ~clk;

  lsq_fwd #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .SEQ_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_v), .alloc_is_store_i(alloc_st), .alloc_seq_i(alloc_seq),
    .alloc_ready_o(alloc_rdy), .alloc_idx_o(alloc_idx),
    .sta_valid_i(sta_v), .sta_idx_i(sta_idx), .sta_addr_i(sta_addr),
    .std_valid_i(std_v), .std_idx_i(std_idx), .std_data_i(std_data),
    .ld_valid_i(ld_v), .ld_idx_i(ld_idx), .ld_addr_i(ld_addr), .cache_rdata_i(cache_rd),
    .ld_hit_o(ld_hit), .ld_wait_o(ld_wait), .ld_data_o(ld_data),
    .retire_i(ret), .retire_ready_o(ret_rdy), .retire_seq_o(ret_seq),
    .cache_we_o(c_we), .cache_addr_o(c_addr), .cache_wdata_o(c_wdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  int m_head = 0, m_cnt = 0;
  bit m_st[D], m_av[D], m_dv[D];
  int m_a[D], m_d[D], m_seq[D];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return m_cnt > 0 && (!m_st[m_head] || (m_av[m_head] && m_dv[m_head]));
  endfunction

  task automatic cyc(input string tag);
    int tl, dl, sel;
    bit rf, exp_we, exp_hit, exp_wait;
    longint exp_d;
    #1;
    tl = (m_head + m_cnt) % D;
    chk(alloc_rdy == (m_cnt < D), "R2", alloc_rdy, m_cnt < D);
    chk(alloc_idx == IW'(tl), "R2", alloc_idx, tl);
    chk(ret_rdy == m_ready(), "R3", ret_rdy, m_ready());
    rf = ret && m_ready();
    exp_we = rf && m_st[m_head];
    chk(c_we == exp_we, "R11", c_we, exp_we);
    if (exp_we) begin
      chk(c_addr == AW'(m_a[m_head]), "R11", c_addr, m_a[m_head]);
      chk(c_wdata == DW'(m_d[m_head]), "R11", c_wdata, m_d[m_head]);
      chk(ret_seq == SW'(m_seq[m_head]), "R11", ret_seq, m_seq[m_head]);
    end
    if (ld_v) begin
      dl = (int'(ld_idx) - m_head + D) % D;
      sel = -1;
      for (int k = 0; k < dl; k++) begin
        int e;
        e = (m_head + k) % D;
        if (m_st[e] && m_av[e] && m_a[e] == int'(ld_addr)) sel = e;
      end
      exp_hit  = (sel >= 0) && m_dv[sel];
      exp_wait = (sel >= 0) && !m_dv[sel];
      exp_d = (sel < 0) ? longint'(cache_rd) : (m_dv[sel] ? longint'(m_d[sel]) : 0);
      chk(ld_hit == exp_hit, tag, ld_hit, exp_hit);
      chk(ld_wait == exp_wait, tag, ld_wait, exp_wait);
      chk(longint'(ld_data) == exp_d, tag, ld_data, exp_d);
    end
    @(posedge clk);
    if (sta_v) begin m_av[sta_idx] = 1; m_a[sta_idx] = int'(sta_addr); end
    if (std_v) begin m_dv[std_idx] = 1; m_d[std_idx] = int'(std_data); end
    if (alloc_v && m_cnt < D) begin
      m_st[tl] = alloc_st; m_av[tl] = 0; m_dv[tl] = 0; m_seq[tl] = int'(alloc_seq);
      m_cnt++;
    end
    if (rf) begin m_head = (m_head + 1) % D; m_cnt--; end
    @(negedge clk);
    alloc_v = 0; sta_v = 0; std_v = 0; ld_v = 0; ret = 0;
  endtask

  task automatic do_alloc(input bit st, input int seq);
    alloc_v = 1; alloc_st = st; alloc_seq = SW'(seq); cyc("R2");
  endtask
  task automatic do_sta(input int i, input int a);
    sta_v = 1; sta_idx = IW'(i); sta_addr = AW'(a); cyc("R3");
  endtask
  task automatic do_std(input int i, input int d);
    std_v = 1; std_idx = IW'(i); std_data = DW'(d); cyc("R3");
  endtask
  task automatic do_load(input int i, input int a, input string tag);
    ld_v = 1; ld_idx = IW'(i); ld_addr = AW'(a); cache_rd = DW'(32'hCA000000 + a); cyc(tag);
  endtask
  task automatic do_retire(input string tag);
    ret = 1; cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_st[i] = 0; m_av[i] = 0; m_dv[i] = 0; end
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(alloc_rdy == 1, "R1", alloc_rdy, 1);
    chk(ret_rdy == 0, "R1", ret_rdy, 0);
    chk(c_we == 0, "R1", c_we, 0);
    rst_n = 1;
    @(negedge clk);
    // slots 0..7: S S L S L S S L
    do_alloc(1, 10); do_alloc(1, 11); do_alloc(0, 12); do_alloc(1, 13);
    do_alloc(0, 14); do_alloc(1, 15);
    do_sta(0, 'h10); do_std(0, 'hA0);
    do_sta(1, 'h10);
    do_load(2, 'h10, "R8");          // youngest older match lacks data
    do_std(1, 'hB1);
    do_load(2, 'h10, "R6");          // slot 1 beats slot 0
    do_load(2, 'h20, "R4");
    do_sta(3, 'h20); do_std(3, 'hC3);
    do_sta(5, 'h10); do_std(5, 'hD5);
    do_load(2, 'h20, "R7");          // slot 3 is younger
    do_load(4, 'h20, "R5");
    do_load(4, 'h10, "R7");          // slot 5 younger, slot 1 used
    do_alloc(1, 16); do_alloc(0, 17);
    do_load(7, 'h10, "R9");          // slot 6 has no address
    do_alloc(1, 18);                 // full: ignored (R2)
    do_retire("R11"); do_retire("R11"); do_retire("R11");
    do_retire("R11"); do_retire("R11"); do_retire("R11");
    do_retire("R12");                // head 6 lacks both halves
    do_std(6, 'h66);                 // data before address (R3)
    do_retire("R12");
    do_sta(6, 'h30);
    // wrap: slots 0,1,2 after 6,7
    do_alloc(1, 19); do_alloc(1, 20); do_alloc(0, 21);
    do_sta(0, 'h30); do_std(0, 'hE0);
    do_load(2, 'h30, "R10");         // slot 0 beats slot 6 across the wrap
    do_load(7, 'h30, "R10");         // load not youngest
    do_sta(1, 'h30);
    do_load(2, 'h30, "R10");         // slot 1 selected, no data yet
    do_std(1, 'hF1);
    do_load(2, 'h30, "R10");
    do_std(0, 'hE2);
    for (int i = 0; i < 5; i++) do_retire("R11");
    do_retire("R12");                // empty
    finish_run();
  end
endmodule